// File: doc/BRIEF.md
# Coprocessor Register Transfer Controller

This block sits on the core side of a coprocessor bus and moves one 32-bit word between a core register and an attached coprocessor. The core issues a transfer with a start strobe. The strobe carries a direction bit, the target coprocessor number, two opcode fields, two coprocessor register fields and the core register index. The block latches these fields and broadcasts them on the bus. It then watches a response from every coprocessor slot.

An accepting coprocessor completes the transfer. In the coprocessor-to-core direction, the returned word goes to the core register write port. If the destination index is the program counter, only the top four bits go to the condition flags. In the core-to-coprocessor direction, the latched register value is presented on the bus in the accept cycle. Busy responses hold the offer open. If no slot responds, the block raises an undefined-instruction trap. A pending interrupt during a busy-wait abandons the handshake, and any retry arrives later as a fresh start.

Top module: `copro_xfer`

## Requirements
- R1: After reset, busValid, done, undefTrap, irqTaken, regWrEn and flagWrEn are all 0.
- R2: A start strobe while idle raises busValid on the next cycle. The latched cpNum, opcode-1, opcode-2, CRn, CRm and direction fields appear on the bus unmodified, and they stay stable while busValid remains high.
- R3: Each slot answers with a 2-bit code at bits [2s+1:2s]: 00 absent, 01 busy, 10 or 11 accept. Any accepting slot during an offer cycle ends the offer, and done pulses in the following cycle.
- R4: In the coprocessor-to-core direction (busToCore=1), with a destination index other than the program counter, regWrEn pulses together with done. regWrAddr then equals the destination index, and regWrData equals the copRdData sampled in the accept cycle.
- R5: When the destination index is the program counter (all ones, 15 by default) in the coprocessor-to-core direction, flagWrEn pulses with flagNzcv equal to bits 31..28 of the returned word, and regWrEn stays low.
- R6: In the core-to-coprocessor direction (busToCore=0), busWrData holds the rdValue sampled at the start strobe for the whole offer, even when rdValue changes later. Completion writes neither the register port nor the flags.
- R7: While at least one slot is busy, none accepts and no interrupt is pending, the offer stays open for any number of cycles and no outcome is signalled.
- R8: An offer cycle in which every slot is absent produces an undefTrap pulse, drops busValid and performs no register or flag write.
- R9: An offer cycle with busy slots, no accepting slot and irqPending high produces an irqTaken pulse, drops busValid and performs no write. An accept in the same cycle as irqPending completes the transfer instead.
- R10: A start strobe while an offer is open is ignored, and the bus fields keep their latched values.
- R11: done, undefTrap and irqTaken are single-cycle pulses, and at most one of them is high in any cycle.
- R12: After an abandoned handshake, a new start latches fresh fields and runs a complete new handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Issue strobe for a transfer |
| reqToCore | input | 1 | Direction: 1 coprocessor-to-core, 0 core-to-coprocessor |
| reqCpNum | input | 4 | Target coprocessor number |
| reqOp1 | input | 3 | First opcode field |
| reqOp2 | input | 3 | Second opcode field |
| reqCrn | input | 4 | First coprocessor register field |
| reqCrm | input | 4 | Second coprocessor register field |
| reqRd | input | 4 | Core register index |
| rdValue | input | 32 | Current value of the core register |
| irqPending | input | 1 | Interrupt waiting to be taken |
| copResp | input | 8 | Per-slot 2-bit response codes |
| copRdData | input | 32 | Word returned by the accepting coprocessor |
| busValid | output | 1 | Offer on the bus is active |
| busToCore | output | 1 | Latched direction |
| busCpNum | output | 4 | Broadcast coprocessor number |
| busOp1 | output | 3 | Broadcast first opcode |
| busOp2 | output | 3 | Broadcast second opcode |
| busCrn | output | 4 | Broadcast first coprocessor register |
| busCrm | output | 4 | Broadcast second coprocessor register |
| busWrData | output | 32 | Word handed to the coprocessor |
| regWrEn | output | 1 | Core register write strobe |
| regWrAddr | output | 4 | Core register write index |
| regWrData | output | 32 | Core register write data |
| flagWrEn | output | 1 | Condition flag write strobe |
| flagNzcv | output | 4 | New N, Z, C, V flag values |
| done | output | 1 | Transfer completed pulse |
| undefTrap | output | 1 | No-acceptance trap pulse |
| irqTaken | output | 1 | Handshake abandoned for interrupt pulse |

## Verification
The assertions assume that the core raises startValid only for transfers it wants issued. They also assume that copResp and copRdData settle before the clock edge, and that irqPending carries meaning only during an offer. The bench drives every input on the falling edge and sets the response codes only after the offer has started. It returns all slots to absent and clears irqPending between scenarios, so each scenario starts from idle. Response codes are never left half-set across an edge.

// File: rtl/copro_xfer_pkg.sv
package copro_xfer_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_OFFER
  } xferState_t;

  typedef struct packed {
    logic capture;
    logic commit;
  } dpCtrl_t;

endpackage

// File: rtl/copro_xfer_ctl.sv
module copro_xfer_ctl
  import copro_xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startValid,
  input  logic    irqPending,
  input  logic    anyAccept,
  input  logic    anyBusy,
  output dpCtrl_t dpCtrl,
  output logic    busValid,
  output logic    done,
  output logic    undefTrap,
  output logic    irqTaken
);

  xferState_t state;

  assign busValid = (state == ST_OFFER);

  always_comb begin
    dpCtrl.capture = (state == ST_IDLE) && startValid;
    dpCtrl.commit  = (state == ST_OFFER) && anyAccept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      undefTrap <= 1'b0;
      irqTaken  <= 1'b0;
    end else begin
      done      <= 1'b0;
      undefTrap <= 1'b0;
      irqTaken  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startValid) state <= ST_OFFER;
        end
        ST_OFFER: begin
          if (anyAccept) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (!anyBusy) begin
            undefTrap <= 1'b1;
            state     <= ST_IDLE;
          end else if (irqPending) begin
            irqTaken <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: outcomes are exclusive and last one cycle
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, undefTrap, irqTaken}));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: an outcome only follows an open offer
  assert_outcome_after_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done || undefTrap || irqTaken) |-> $past(busValid));

  // R7: busy without accept or interrupt keeps the offer open
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !anyAccept && anyBusy && !irqPending) |=> busValid);

  // R9: an abandoned offer is closed
  assert_irq_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irqTaken |-> !busValid);

endmodule

// File: rtl/copro_xfer_dp.sv
module copro_xfer_dp
  import copro_xfer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CPN_W     = 4,
  parameter int OP1_W     = 3,
  parameter int OP2_W     = 3,
  parameter int CREG_W    = 4,
  parameter int REG_W     = 4,
  parameter int NUM_SLOTS = 4,
  localparam int RESP_W   = 2 * NUM_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           dpCtrl,
  input  logic              busValid,
  input  logic              reqToCore,
  input  logic [CPN_W-1:0]  reqCpNum,
  input  logic [OP1_W-1:0]  reqOp1,
  input  logic [OP2_W-1:0]  reqOp2,
  input  logic [CREG_W-1:0] reqCrn,
  input  logic [CREG_W-1:0] reqCrm,
  input  logic [REG_W-1:0]  reqRd,
  input  logic [DATA_W-1:0] rdValue,
  input  logic [RESP_W-1:0] copResp,
  input  logic [DATA_W-1:0] copRdData,
  output logic              anyAccept,
  output logic              anyBusy,
  output logic              busToCore,
  output logic [CPN_W-1:0]  busCpNum,
  output logic [OP1_W-1:0]  busOp1,
  output logic [OP2_W-1:0]  busOp2,
  output logic [CREG_W-1:0] busCrn,
  output logic [CREG_W-1:0] busCrm,
  output logic [DATA_W-1:0] busWrData,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              flagWrEn,
  output logic [3:0]        flagNzcv
);

  localparam logic [REG_W-1:0] PC_IDX = {REG_W{1'b1}};

  logic [NUM_SLOTS-1:0] acceptVec;
  logic [NUM_SLOTS-1:0] busyVec;
  logic [REG_W-1:0]     latRd;
  logic                 rdIsPc;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign acceptVec[s] = copResp[2*s+1];
    assign busyVec[s]   = copResp[2*s] & ~copResp[2*s+1];
  end

  assign anyAccept = |acceptVec;
  assign anyBusy   = |busyVec;
  assign rdIsPc    = (latRd == PC_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busToCore <= 1'b0;
      busCpNum  <= '0;
      busOp1    <= '0;
      busOp2    <= '0;
      busCrn    <= '0;
      busCrm    <= '0;
      busWrData <= '0;
      latRd     <= '0;
    end else if (dpCtrl.capture) begin
      busToCore <= reqToCore;
      busCpNum  <= reqCpNum;
      busOp1    <= reqOp1;
      busOp2    <= reqOp2;
      busCrn    <= reqCrn;
      busCrm    <= reqCrm;
      busWrData <= rdValue;
      latRd     <= reqRd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
      flagWrEn  <= 1'b0;
      flagNzcv  <= '0;
    end else begin
      regWrEn  <= dpCtrl.commit && busToCore && !rdIsPc;
      flagWrEn <= dpCtrl.commit && busToCore && rdIsPc;
      if (dpCtrl.commit && busToCore) begin
        regWrAddr <= latRd;
        regWrData <= copRdData;
        flagNzcv  <= copRdData[DATA_W-1 -: 4];
      end
    end
  end

  // R5: the program counter is never written through the register port
  assert_pc_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && flagWrEn));
  assert_no_pc_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> (regWrAddr != PC_IDX));

  // R2: fields hold while the offer is open
  assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && $past(busValid)) |->
      ($stable(busCpNum) && $stable(busOp1) && $stable(busOp2) &&
       $stable(busCrn) && $stable(busCrm) && $stable(busToCore) && $stable(busWrData)));

  // R6: writes to the core only follow a core-bound offer
  assert_write_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn || flagWrEn) |-> $past(busValid && busToCore));

endmodule

// File: rtl/copro_xfer.sv
module copro_xfer
  import copro_xfer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CPN_W     = 4,
  parameter int OP1_W     = 3,
  parameter int OP2_W     = 3,
  parameter int CREG_W    = 4,
  parameter int REG_W     = 4,
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   startValid,
  input  logic                   reqToCore,
  input  logic [CPN_W-1:0]       reqCpNum,
  input  logic [OP1_W-1:0]       reqOp1,
  input  logic [OP2_W-1:0]       reqOp2,
  input  logic [CREG_W-1:0]      reqCrn,
  input  logic [CREG_W-1:0]      reqCrm,
  input  logic [REG_W-1:0]       reqRd,
  input  logic [DATA_W-1:0]      rdValue,
  input  logic                   irqPending,
  input  logic [2*NUM_SLOTS-1:0] copResp,
  input  logic [DATA_W-1:0]      copRdData,
  output logic                   busValid,
  output logic                   busToCore,
  output logic [CPN_W-1:0]       busCpNum,
  output logic [OP1_W-1:0]       busOp1,
  output logic [OP2_W-1:0]       busOp2,
  output logic [CREG_W-1:0]      busCrn,
  output logic [CREG_W-1:0]      busCrm,
  output logic [DATA_W-1:0]      busWrData,
  output logic                   regWrEn,
  output logic [REG_W-1:0]       regWrAddr,
  output logic [DATA_W-1:0]      regWrData,
  output logic                   flagWrEn,
  output logic [3:0]             flagNzcv,
  output logic                   done,
  output logic                   undefTrap,
  output logic                   irqTaken
);

  dpCtrl_t dpCtrl;
  logic    anyAccept;
  logic    anyBusy;

  copro_xfer_ctl i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startValid (startValid),
    .irqPending (irqPending),
    .anyAccept  (anyAccept),
    .anyBusy    (anyBusy),
    .dpCtrl     (dpCtrl),
    .busValid   (busValid),
    .done       (done),
    .undefTrap  (undefTrap),
    .irqTaken   (irqTaken)
  );

  copro_xfer_dp #(
    .DATA_W    (DATA_W),
    .CPN_W     (CPN_W),
    .OP1_W     (OP1_W),
    .OP2_W     (OP2_W),
    .CREG_W    (CREG_W),
    .REG_W     (REG_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .dpCtrl    (dpCtrl),
    .busValid  (busValid),
    .reqToCore (reqToCore),
    .reqCpNum  (reqCpNum),
    .reqOp1    (reqOp1),
    .reqOp2    (reqOp2),
    .reqCrn    (reqCrn),
    .reqCrm    (reqCrm),
    .reqRd     (reqRd),
    .rdValue   (rdValue),
    .copResp   (copResp),
    .copRdData (copRdData),
    .anyAccept (anyAccept),
    .anyBusy   (anyBusy),
    .busToCore (busToCore),
    .busCpNum  (busCpNum),
    .busOp1    (busOp1),
    .busOp2    (busOp2),
    .busCrn    (busCrn),
    .busCrm    (busCrm),
    .busWrData (busWrData),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .flagWrEn  (flagWrEn),
    .flagNzcv  (flagNzcv)
  );

  // R8: a trap performs no write
  assert_trap_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    undefTrap |-> (!regWrEn && !flagWrEn));

  // R9: an abandoned handshake performs no write
  assert_irq_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irqTaken |-> (!regWrEn && !flagWrEn));

endmodule

// File: tb/test_copro_xfer.sv
`timescale 1ns/1ps
module test_copro_xfer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startValid = 1'b0;
  logic        reqToCore = 1'b0;
  logic [3:0]  reqCpNum = '0;
  logic [2:0]  reqOp1 = '0;
  logic [2:0]  reqOp2 = '0;
  logic [3:0]  reqCrn = '0;
  logic [3:0]  reqCrm = '0;
  logic [3:0]  reqRd = '0;
  logic [31:0] rdValue = '0;
  logic        irqPending = 1'b0;
  logic [7:0]  copResp = '0;
  logic [31:0] copRdData = '0;
  logic        busValid, busToCore;
  logic [3:0]  busCpNum, busCrn, busCrm;
  logic [2:0]  busOp1, busOp2;
  logic [31:0] busWrData;
  logic        regWrEn;
  logic [3:0]  regWrAddr;
  logic [31:0] regWrData;
  logic        flagWrEn;
  logic [3:0]  flagNzcv;
  logic        done, undefTrap, irqTaken;

  int nCompared = 0;
  int nMismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  copro_xfer i_copro_xfer (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .reqToCore(reqToCore),
    .reqCpNum(reqCpNum), .reqOp1(reqOp1), .reqOp2(reqOp2), .reqCrn(reqCrn),
    .reqCrm(reqCrm), .reqRd(reqRd), .rdValue(rdValue), .irqPending(irqPending),
    .copResp(copResp), .copRdData(copRdData), .busValid(busValid),
    .busToCore(busToCore), .busCpNum(busCpNum), .busOp1(busOp1), .busOp2(busOp2),
    .busCrn(busCrn), .busCrm(busCrm), .busWrData(busWrData), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .flagWrEn(flagWrEn),
    .flagNzcv(flagNzcv), .done(done), .undefTrap(undefTrap), .irqTaken(irqTaken)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic dir, input logic [3:0] cp, input logic [2:0] o1,
                       input logic [2:0] o2, input logic [3:0] cn, input logic [3:0] cm,
                       input logic [3:0] rd, input logic [31:0] rv);
    @(negedge clk);
    startValid = 1'b1; reqToCore = dir; reqCpNum = cp; reqOp1 = o1; reqOp2 = o2;
    reqCrn = cn; reqCrm = cm; reqRd = rd; rdValue = rv;
    tick();
    startValid = 1'b0;
  endtask

  task automatic idleGap();
    copResp = '0; irqPending = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    check({busValid, done, undefTrap, irqTaken, regWrEn, flagWrEn} == 6'b0, "R1",
          "outputs after reset", {26'b0, busValid, done, undefTrap, irqTaken, regWrEn, flagWrEn}, 0);
  endtask

  task automatic t_read();
    issue(1'b1, 4'd2, 3'd4, 3'd6, 4'd3, 4'd4, 4'd3, 32'h0);
    check(busValid, "R2", "busValid on offer", busValid, 1);
    check({busCpNum, busOp1, busOp2, busCrn, busCrm, busToCore} ==
          {4'd2, 3'd4, 3'd6, 4'd3, 4'd4, 1'b1}, "R2", "bus fields",
          {11'b0, busCpNum, busOp1, busOp2, busCrn, busCrm, busToCore},
          {11'b0, 4'd2, 3'd4, 3'd6, 4'd3, 4'd4, 1'b1});
    copResp = 8'b00_10_00_00; copRdData = 32'h1234_5678;
    tick();
    copResp = '0; copRdData = '0;
    check(done, "R3", "done after accept", done, 1);
    check(regWrEn && regWrAddr == 4'd3, "R4", "reg write addr", regWrAddr, 3);
    check(regWrData == 32'h1234_5678, "R4", "reg write data", regWrData, 32'h1234_5678);
    check(!flagWrEn, "R4", "no flag write", flagWrEn, 0);
    tick();
    check(!done && !regWrEn, "R11", "done single cycle", {30'b0, done, regWrEn}, 0);
    idleGap();
  endtask

  task automatic t_pc();
    issue(1'b1, 4'd1, 3'd0, 3'd0, 4'd0, 4'd0, 4'd15, 32'h0);
    copResp = 8'b11_00_00_00; copRdData = 32'hA000_1234;
    tick();
    copResp = '0;
    check(flagWrEn && flagNzcv == 4'hA, "R5", "flags from top bits", flagNzcv, 4'hA);
    check(!regWrEn, "R5", "program counter not written", regWrEn, 0);
    check(done && !undefTrap && !irqTaken, "R11", "only done",
          {29'b0, done, undefTrap, irqTaken}, 3'b100);
    idleGap();
  endtask

  task automatic t_write();
    issue(1'b0, 4'd14, 3'd3, 3'd0, 4'd1, 4'd2, 4'd0, 32'hCAFE_BABE);
    rdValue = 32'h0BAD_F00D;
    check(busWrData == 32'hCAFE_BABE, "R6", "write data latched", busWrData, 32'hCAFE_BABE);
    check(!busToCore, "R6", "direction bit", busToCore, 0);
    copResp = 8'b00_00_00_10;
    tick();
    copResp = '0;
    check(done, "R3", "done on write", done, 1);
    check(!regWrEn && !flagWrEn, "R6", "no core write", {30'b0, regWrEn, flagWrEn}, 0);
    idleGap();
  endtask

  task automatic t_busy();
    issue(1'b1, 4'd5, 3'd1, 3'd2, 4'd6, 4'd7, 4'd9, 32'h0);
    copResp = 8'b01_00_00_00;
    for (int i = 0; i < 5; i++) begin
      if (i == 2) begin
        @(negedge clk);
        startValid = 1'b1; reqCpNum = 4'd11; reqOp1 = 3'd7; reqRd = 4'd1; reqToCore = 1'b0;
      end
      tick();
      startValid = 1'b0;
      check(busValid && !done && !undefTrap && !irqTaken, "R7", "still waiting",
            {28'b0, busValid, done, undefTrap, irqTaken}, 4'b1000);
    end
    check(busCpNum == 4'd5 && busOp1 == 3'd1 && busToCore, "R10", "start ignored",
          {24'b0, busCpNum, 1'b0, busOp1}, {24'b0, 4'd5, 1'b0, 3'd1});
    copResp = 8'b01_10_00_00; copRdData = 32'h0000_00FF;
    tick();
    copResp = '0;
    check(done && regWrAddr == 4'd9 && regWrData == 32'hFF, "R7", "completes after busy",
          regWrData, 32'hFF);
    idleGap();
  endtask

  task automatic t_trap();
    issue(1'b1, 4'd7, 3'd0, 3'd0, 4'd0, 4'd0, 4'd2, 32'h0);
    tick();
    check(undefTrap && !done && !irqTaken, "R8", "trap pulse",
          {29'b0, undefTrap, done, irqTaken}, 3'b100);
    check(!busValid && !regWrEn && !flagWrEn, "R8", "no transfer",
          {29'b0, busValid, regWrEn, flagWrEn}, 0);
    tick();
    check(!undefTrap, "R11", "trap single cycle", undefTrap, 0);
  endtask

  task automatic t_irq();
    issue(1'b1, 4'd3, 3'd2, 3'd1, 4'd5, 4'd8, 4'd4, 32'h0);
    copResp = 8'b00_00_01_00;
    tick();
    irqPending = 1'b1;
    tick();
    irqPending = 1'b0; copResp = '0;
    check(irqTaken && !done && !undefTrap, "R9", "abandon pulse",
          {29'b0, irqTaken, done, undefTrap}, 3'b100);
    check(!busValid && !regWrEn && !flagWrEn, "R9", "no transfer on abandon",
          {29'b0, busValid, regWrEn, flagWrEn}, 0);
    tick();
    issue(1'b1, 4'd3, 3'd5, 3'd1, 4'd5, 4'd8, 4'd6, 32'h0);
    check(busValid && busOp1 == 3'd5, "R12", "fresh offer", busOp1, 5);
    copResp = 8'b00_00_10_00; copRdData = 32'h5555_AAAA;
    tick();
    copResp = '0;
    check(done && regWrAddr == 4'd6 && regWrData == 32'h5555_AAAA, "R12", "retry completes",
          regWrAddr, 6);
    idleGap();
  endtask

  task automatic t_irqAccept();
    issue(1'b1, 4'd0, 3'd0, 3'd0, 4'd0, 4'd0, 4'd8, 32'h0);
    copResp = 8'b00_00_01_10; irqPending = 1'b1; copRdData = 32'h0000_0042;
    tick();
    copResp = '0; irqPending = 1'b0;
    check(done && !irqTaken, "R9", "accept beats interrupt", {30'b0, done, irqTaken}, 2'b10);
    check(regWrEn && regWrData == 32'h42, "R4", "data on accept", regWrData, 32'h42);
    idleGap();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_read();
    t_pc();
    t_write();
    t_busy();
    t_trap();
    t_irq();
    t_irqAccept();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule